// File: doc/BRIEF.md
# Programmable Pulse Generator Timer

This block makes a repeating rectangular wave from a 16-bit up-counter and two compare values. The period value sets the length of each cycle. The counter runs from zero up to the period value and then clears on the next count-clock tick. The width value sets how many counts at the start of each cycle the output stays high. Each compare match raises its own one-cycle interrupt strobe. The counter advances only on system-clock cycles where the count-clock enable is high, so a prescaler outside the block sets the time base.

Software writes the period and width through two write ports. Each write goes into a holding buffer. While the timer is stopped, the buffers pass straight into the active compare values. While it runs, they pass only at the clear that follows a period match, so a rewrite never bends the cycle in progress. The timer runs only while the run control is high and the two-bit mode field selects clear-and-start-on-period-match (binary 11).

The control state machine has two states. In `ST_IDLE` the counter is held at zero, the output is low and the compare values follow the buffers. In `ST_RUN` the timer counts. The transition `ST_IDLE -> ST_RUN` is taken when run is high and the mode is 11. The transition `ST_RUN -> ST_IDLE` is taken as soon as either of those conditions drops.

Top module: `ppg_timer`

## Requirements
- R1: Unless run is high and mode equals binary 11, the block is idle: the counter is zero, the pulse output is low and both strobes are low.
- R2: While running, the period-match strobe recurs every P+1 enabled count-clock cycles, where P is the period value, and the counter reads zero on the cycle after a match.
- R3: When the width value W is less than P, the output is high on counts 0 through W and low on counts W+1 through P, giving W+1 high counts per cycle.
- R4: When W is greater than or equal to P, the output stays high for every count of the cycle.
- R5: The period-match strobe is high for exactly one system-clock cycle per match, only on a cycle where the count-clock enable is high and the counter equals P.
- R6: The width-match strobe is high on the enabled cycle where the counter equals W, once per cycle when W is not greater than P, and never when W exceeds P.
- R7: A period or width write made while running takes effect only at the next clear after a period match. The cycle in progress keeps its old values.
- R8: The counter holds its value on cycles where the count-clock enable is low.
- R9: The counter never exceeds the active period value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| cnt_en | input | 1 | Count-clock enable; the counter advances on cycles where it is high |
| mode | input | 2 | Operating mode; only binary 11 (clear and start on period match) runs the timer |
| run | input | 1 | Run control |
| per_we | input | 1 | Period buffer write strobe |
| per_wdata | input | 16 | Period value to write |
| wid_we | input | 1 | Width buffer write strobe |
| wid_wdata | input | 16 | Width value to write |
| pulse_o | output | 1 | Pulse output |
| per_irq_o | output | 1 | Period-match interrupt strobe |
| wid_irq_o | output | 1 | Width-match interrupt strobe |

## Verification
The bench sweeps every pairing of period values 0 to 5 with width values 0 to 6, so width below, equal to and above the period all occur, and measures two complete cycles of each. These runs tell an off-by-one in the period apart from one in the high time, and show where the full-duty case starts. Alternate configurations gate the count clock on every third cycle. This separates counting in enabled cycles from counting in system cycles, and catches any strobe that fires on a disabled cycle. Further runs cover the maximum period with half and full width, and a width rewrite in mid-cycle. The rewrite run must leave the current cycle unchanged and change only the next one. Mode values other than 11 and a low run control must keep the outputs silent.

// File: rtl/ppg_pkg.sv
package ppg_pkg;
    localparam int MODE_W = 2;
    localparam logic [MODE_W-1:0] MODE_CLR_START = 2'b11;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } ppg_state_e;
endpackage

// File: rtl/ppg_ctrl.sv
module ppg_ctrl
    import ppg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              run,
    input  logic [MODE_W-1:0] mode,
    output logic              run_st,
    output logic              stay_run
);
    ppg_state_e state_q, state_d;
    logic       go;

    assign go = run && (mode == MODE_CLR_START);

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (go)  state_d = ST_RUN;
            ST_RUN:  if (!go) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        run_st   = (state_q == ST_RUN);
        stay_run = run_st && (state_d == ST_RUN);
    end
endmodule

// File: rtl/ppg_counter.sv
module ppg_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             hold_zero,
    input  logic             cnt_en,
    input  logic             wrap,
    output logic [CNT_W-1:0] cnt
);
    always_ff @(posedge clk) begin
        if (rst || hold_zero)  cnt <= '0;
        else if (cnt_en) begin
            if (wrap) cnt <= '0;
            else      cnt <= cnt + CNT_W'(1);
        end
    end

    p_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (!cnt_en && !hold_zero) |=> $stable(cnt));
endmodule

// File: rtl/ppg_compare.sv
module ppg_compare #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             per_we,
    input  logic [CNT_W-1:0] per_wdata,
    input  logic             wid_we,
    input  logic [CNT_W-1:0] wid_wdata,
    input  logic             reload,
    input  logic             run_st,
    input  logic             cnt_en,
    input  logic [CNT_W-1:0] cnt,
    output logic [CNT_W-1:0] per_act,
    output logic [CNT_W-1:0] wid_act,
    output logic             pulse,
    output logic             per_hit,
    output logic             wid_hit
);
    logic [CNT_W-1:0] per_buf, wid_buf;

    always_ff @(posedge clk) begin
        if (rst) begin
            per_buf <= '1;
            wid_buf <= '0;
            per_act <= '1;
            wid_act <= '0;
        end else begin
            if (per_we) per_buf <= per_wdata;
            if (wid_we) wid_buf <= wid_wdata;
            if (reload) begin
                per_act <= per_buf;
                wid_act <= wid_buf;
            end
        end
    end

    always_comb begin
        pulse   = run_st && (cnt <= wid_act);
        per_hit = run_st && cnt_en && (cnt == per_act);
        wid_hit = run_st && cnt_en && (cnt == wid_act);
    end
endmodule

// File: rtl/ppg_timer.sv
module ppg_timer
    import ppg_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cnt_en,
    input  logic [MODE_W-1:0] mode,
    input  logic              run,
    input  logic              per_we,
    input  logic [CNT_W-1:0]  per_wdata,
    input  logic              wid_we,
    input  logic [CNT_W-1:0]  wid_wdata,
    output logic              pulse_o,
    output logic              per_irq_o,
    output logic              wid_irq_o
);
    logic             run_st, stay_run, per_hit, wid_hit, pulse, reload;
    logic [CNT_W-1:0] cnt, per_act, wid_act;

    assign reload = !stay_run || per_hit;

    ppg_ctrl u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .run      (run),
        .mode     (mode),
        .run_st   (run_st),
        .stay_run (stay_run)
    );

    ppg_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk       (clk),
        .rst       (rst),
        .hold_zero (!stay_run),
        .cnt_en    (cnt_en),
        .wrap      (per_hit),
        .cnt       (cnt)
    );

    ppg_compare #(.CNT_W(CNT_W)) u_cmp (
        .clk       (clk),
        .rst       (rst),
        .per_we    (per_we),
        .per_wdata (per_wdata),
        .wid_we    (wid_we),
        .wid_wdata (wid_wdata),
        .reload    (reload),
        .run_st    (run_st),
        .cnt_en    (cnt_en),
        .cnt       (cnt),
        .per_act   (per_act),
        .wid_act   (wid_act),
        .pulse     (pulse),
        .per_hit   (per_hit),
        .wid_hit   (wid_hit)
    );

    assign pulse_o   = pulse;
    assign per_irq_o = per_hit;
    assign wid_irq_o = wid_hit;

    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (rst)
        !run_st |-> (cnt == '0 && !pulse_o && !per_irq_o && !wid_irq_o));

    p_wrap_r2: assert property (@(posedge clk) disable iff (rst)
        per_irq_o |=> (cnt == '0));

    p_full_duty_r4: assert property (@(posedge clk) disable iff (rst)
        (run_st && wid_act >= per_act) |-> pulse_o);

    p_wid_steady_r7: assert property (@(posedge clk) disable iff (rst)
        (stay_run && !per_irq_o) |=> $stable(wid_act) && $stable(per_act));

    p_cnt_bound_r9: assert property (@(posedge clk) disable iff (rst)
        run_st |-> (cnt <= per_act));
endmodule

// File: tb/ppg_timer_bench.sv
module ppg_timer_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cnt_en = 1'b0;
    logic [1:0]  mode = 2'b11;
    logic        run = 1'b0;
    logic        per_we = 1'b0;
    logic [15:0] per_wdata = '0;
    logic        wid_we = 1'b0;
    logic [15:0] wid_wdata = '0;
    logic        pulse_o, per_irq_o, wid_irq_o;

    int errors = 0;
    int checks = 0;
    int cycles = 0;

    always #10 clk = ~clk;

    ppg_timer u_ppg_timer (
        .clk(clk), .rst(rst), .cnt_en(cnt_en), .mode(mode), .run(run),
        .per_we(per_we), .per_wdata(per_wdata), .wid_we(wid_we),
        .wid_wdata(wid_wdata), .pulse_o(pulse_o), .per_irq_o(per_irq_o),
        .wid_irq_o(wid_irq_o)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic configure(input logic [15:0] p, input logic [15:0] w);
        @(negedge clk);
        run = 1'b0; cnt_en = 1'b0; mode = 2'b11;
        per_we = 1'b1; per_wdata = p; wid_we = 1'b1; wid_wdata = w;
        @(negedge clk);
        per_we = 1'b0; wid_we = 1'b0;
        repeat (2) @(negedge clk);
        run = 1'b1;
    endtask

    task automatic run_window(input int pat, input int wr_at, input logic [15:0] wr_val,
                              output int n, output int hi, output int wi, output int bad);
        int k;
        k = 0; n = 0; hi = 0; wi = 0; bad = 0;
        while (1) begin
            @(negedge clk);
            wid_we    = (k == wr_at);
            wid_wdata = wr_val;
            cnt_en    = (pat == 0) ? 1'b1 : ((k % 3) != 2);
            k++;
            #1;
            if (cnt_en) begin
                n++;
                if (pulse_o)   hi++;
                if (wid_irq_o) wi++;
                if (per_irq_o) break;
            end else if (per_irq_o || wid_irq_o) begin
                bad++;
            end
        end
        wid_we = 1'b0;
    endtask

    task automatic check_cycle(input int p, input int w, input int n, input int hi,
                               input int wi, input int bad, input int pat);
        int exp_hi;
        exp_hi = (w >= p) ? p + 1 : w + 1;
        chk(n == p + 1, (pat != 0) ? "R2/R8 period in enabled counts" : "R2 period", n, p + 1);
        chk(hi == exp_hi, (w >= p) ? "R4 full duty" : "R3 high time", hi, exp_hi);
        chk(wi == ((w <= p) ? 1 : 0), "R6 width strobe count", wi, (w <= p) ? 1 : 0);
        chk(bad == 0, "R5 strobe on disabled cycle", bad, 0);
    endtask

    initial begin
        while (1) begin
            @(posedge clk);
            cycles++;
            if (cycles > 195000) begin
                errors++; checks++;
                $display("FAIL watchdog: actual=%0d expected=%0d", cycles, 195000);
                $display("Result: errors=%0d of %0d checks", errors, checks);
                $finish;
            end
        end
    end

    initial begin
        int n, hi, wi, bad, quiet;
        repeat (3) @(negedge clk);
        #1;
        chk(!pulse_o && !per_irq_o && !wid_irq_o, "R1 reset state",
            {pulse_o, per_irq_o, wid_irq_o}, 0);
        @(negedge clk);
        rst = 1'b0;

        // R1: wrong mode or run low keeps the outputs silent
        configure(16'd3, 16'd1);
        mode = 2'b10;
        quiet = 0;
        repeat (8) begin
            @(negedge clk); cnt_en = 1'b1; #1;
            if (pulse_o || per_irq_o || wid_irq_o) quiet++;
        end
        chk(quiet == 0, "R1 mode 10 idle", quiet, 0);
        @(negedge clk); mode = 2'b11; run = 1'b0;
        quiet = 0;
        repeat (8) begin
            @(negedge clk); cnt_en = 1'b1; #1;
            if (pulse_o || per_irq_o || wid_irq_o) quiet++;
        end
        chk(quiet == 0, "R1 run low idle", quiet, 0);

        // Sweep of small periods and widths (R2 R3 R4 R5 R6 R8)
        for (int p = 0; p <= 5; p++) begin
            for (int w = 0; w <= 6; w++) begin
                int pat;
                pat = (p + w) % 2;
                configure(p[15:0], w[15:0]);
                run_window(pat, -1, 16'd0, n, hi, wi, bad);
                check_cycle(p, w, n, hi, wi, bad, pat);
                run_window(pat, -1, 16'd0, n, hi, wi, bad);
                check_cycle(p, w, n, hi, wi, bad, pat);
            end
        end

        // R7: width rewrite mid-cycle applies from the next cycle only
        configure(16'd9, 16'd2);
        run_window(0, -1, 16'd0, n, hi, wi, bad);
        chk(hi == 3, "R7 before rewrite", hi, 3);
        run_window(0, 3, 16'd6, n, hi, wi, bad);
        chk(hi == 3, "R7 current cycle unchanged", hi, 3);
        chk(n == 10, "R7 period unchanged", n, 10);
        run_window(0, -1, 16'd0, n, hi, wi, bad);
        chk(hi == 7, "R7 new width applied", hi, 7);
        chk(wi == 1, "R6 strobe after rewrite", wi, 1);

        // Maximum period (R2 R3 R4 R9)
        configure(16'hFFFF, 16'h7FFF);
        run_window(0, -1, 16'd0, n, hi, wi, bad);
        check_cycle(65535, 32767, n, hi, wi, bad, 0);
        configure(16'hFFFF, 16'hFFFF);
        run_window(0, -1, 16'd0, n, hi, wi, bad);
        check_cycle(65535, 65535, n, hi, wi, bad, 0);
        chk(n == 65536, "R9 counter reaches top and wraps", n, 65536);

        @(negedge clk); run = 1'b0;
        repeat (2) @(negedge clk);
        #1;
        chk(!pulse_o, "R1 output low after stop", pulse_o, 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule